// File: doc/BRIEF.md
# Tagged-Token Dataflow Execution Tile

This tile executes a small static dataflow graph fragment without a program counter. Software loads up to eight static instructions, each with an opcode and a list of up to four destinations. Operand tokens arrive carrying the instruction slot they target, the operand port they fill, a dynamic instance tag and a data value. The tile pairs tokens that share both slot and tag in an eight-entry matching store. When an entry holds every operand its opcode needs, the instruction fires. The results leave as tokens on a valid/ready output, one token per selected destination.

Control flow is carried by three operations. A select picks one of two data operands with a predicate. A steer sends its data to one of two destination halves with a predicate. A tag-advance passes its value unchanged and raises the tag by one. All other operations copy the firing instance's tag to every output token. A full matching store back-pressures the token input and never discards a token. When several entries are complete at once, the entry allocated earliest fires first.

Top module: `df_tile`

## Requirements
- R1: After reset the output is not valid, the token input is ready and no instruction instance is pending.
- R2: A load-port write stores into slot `ld_slot_i` the opcode `ld_op_i` (0 add, 1 subtract, 2 and, 3 xor, 4 select, 5 steer, 6 tag-advance, 7 pass) and four destinations. Destination k occupies bits [6k+5:6k] of `ld_dst_i` as {valid, slot[2:0], port[1:0]}.
- R3: Tokens are combined only when both slot and tag are equal. Two instances of one slot with different tags produce separate results, and the order of operand arrival does not matter.
- R4: An instance fires only once its needed ports have arrived: ports 0 and 1 for add, subtract, and, xor and steer; ports 0, 1 and 2 for select; port 0 only for tag-advance and pass.
- R5: Add, subtract, and, and xor produce p0+p1, p0-p1, p0&p1 and p0^p1, modulo 2^16.
- R6: Select outputs p1 when p0 is nonzero and p2 when p0 is zero.
- R7: Steer outputs p1 to destinations 0 and 1 when p0 is nonzero and to destinations 2 and 3 when p0 is zero. No token goes to the other pair.
- R8: Tag-advance outputs p0 with tag+1 modulo 2^8. Every other operation copies the instance tag unchanged.
- R9: A fired instruction emits exactly one token per valid selected destination, in ascending destination index, with that destination's slot and port on the output.
- R10: While `out_valid_o` is high and `out_ready_i` is low, all output fields hold their values.
- R11: When all eight entries are occupied and an arriving token matches none of them, `tok_ready_o` is low and the token is later accepted intact. A token that matches an occupied entry is still accepted.
- R12: Among complete entries, the one allocated earliest fires first, regardless of its storage position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Instruction write strobe |
| ld_slot_i | input | 3 | Slot written |
| ld_op_i | input | 3 | Opcode written |
| ld_dst_i | input | 24 | Four destinations, 6 bits each |
| tok_valid_i | input | 1 | Incoming token present |
| tok_ready_o | output | 1 | Incoming token accepted this cycle |
| tok_slot_i | input | 3 | Target instruction slot |
| tok_port_i | input | 2 | Target operand port (0 to 2) |
| tok_tag_i | input | 8 | Dynamic instance tag |
| tok_data_i | input | 16 | Operand value |
| out_valid_o | output | 1 | Result token present |
| out_ready_i | input | 1 | Consumer takes result token |
| out_slot_o | output | 3 | Destination slot |
| out_port_o | output | 2 | Destination port |
| out_tag_o | output | 8 | Result tag |
| out_data_o | output | 16 | Result value |

## Verification
The properties assume well-formed token streams. No port is delivered twice to the same (slot, tag) instance, port values stay below 3, and a slot is not rewritten while it has a pending instance. The bench holds each token until it is accepted, gives every instance a fresh tag, and loads all instructions before sending tokens to them. Under those conditions the properties cover output stability under back-pressure, stalling only when the store is full, a single firing winner, and the tag rule for each opcode.

// File: rtl/df_pkg.sv
package df_pkg;
  localparam int NPORT = 3;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_XOR   = 3'd3,
    OP_SEL   = 3'd4,
    OP_STEER = 3'd5,
    OP_WADV  = 3'd6,
    OP_PASS  = 3'd7
  } df_op_e;

  function automatic logic [NPORT-1:0] op_need(df_op_e op);
    case (op)
      OP_SEL:           return 3'b111;
      OP_WADV, OP_PASS: return 3'b001;
      default:          return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/df_alu.sv
module df_alu import df_pkg::*; #(
  parameter int DW   = 16,
  parameter int TW   = 8,
  parameter int NDST = 4,
  parameter int DSTW = 6
) (
  input  df_op_e                     op_i,
  input  logic [NPORT-1:0][DW-1:0]   opnd_i,
  input  logic [TW-1:0]              tag_i,
  input  logic [NDST-1:0][DSTW-1:0]  dst_i,
  output logic [DW-1:0]              data_o,
  output logic [TW-1:0]              tag_o,
  output logic [NDST-1:0]            mask_o
);
  localparam int HALF = NDST / 2;

  logic [NDST-1:0] dv, lo;
  logic            pred;

  always_comb begin
    for (int k = 0; k < NDST; k++) begin
      dv[k] = dst_i[k][DSTW-1];
      lo[k] = (k < HALF);
    end
    pred = |opnd_i[0];
    case (op_i)
      OP_ADD:   data_o = opnd_i[0] + opnd_i[1];
      OP_SUB:   data_o = opnd_i[0] - opnd_i[1];
      OP_AND:   data_o = opnd_i[0] & opnd_i[1];
      OP_XOR:   data_o = opnd_i[0] ^ opnd_i[1];
      OP_SEL:   data_o = pred ? opnd_i[1] : opnd_i[2];
      OP_STEER: data_o = opnd_i[1];
      default:  data_o = opnd_i[0];
    endcase
    tag_o  = (op_i == OP_WADV) ? tag_i + 1'b1 : tag_i;
    mask_o = dv;
    if (op_i == OP_STEER) mask_o = pred ? (dv & lo) : (dv & ~lo);
  end
endmodule

// File: rtl/df_match.sv
module df_match import df_pkg::*; #(
  parameter  int NSET  = 8,
  parameter  int NSLOT = 8,
  parameter  int TW    = 8,
  parameter  int DW    = 16,
  localparam int SW    = $clog2(NSLOT),
  localparam int IW    = $clog2(NSET),
  localparam int PW    = $clog2(NPORT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tok_valid_i,
  output logic                           tok_ready_o,
  input  logic [SW-1:0]                  tok_slot_i,
  input  logic [PW-1:0]                  tok_port_i,
  input  logic [TW-1:0]                  tok_tag_i,
  input  logic [DW-1:0]                  tok_data_i,
  input  logic [NSLOT-1:0][NPORT-1:0]    need_i,
  input  logic                           fire_en_i,
  output logic                           fire_take_o,
  output logic [NSET-1:0]                fire_oh_o,
  output logic [SW-1:0]                  fire_slot_o,
  output logic [TW-1:0]                  fire_tag_o,
  output logic [NPORT-1:0][DW-1:0]       fire_opnd_o,
  output logic [NSET-1:0]                busy_o
);
  logic [NSET-1:0]                    vld_q;
  logic [NSET-1:0][SW-1:0]            slot_q;
  logic [NSET-1:0][TW-1:0]            tag_q;
  logic [NSET-1:0][NPORT-1:0]         have_q;
  logic [NSET-1:0][NPORT-1:0][DW-1:0] opnd_q;
  logic [NSET-1:0][NSET-1:0]          older_q;  // [i][j]: i allocated before j

  logic [NSET-1:0]  hit, rdy, win;
  logic [NPORT-1:0] pbit;
  logic [IW-1:0]    hit_idx, alloc_idx, fire_idx, wr_idx;
  logic             any_hit, any_free, acc;

  always_comb begin
    hit_idx   = '0;
    alloc_idx = '0;
    fire_idx  = '0;
    for (int p = 0; p < NPORT; p++) pbit[p] = (tok_port_i == PW'(p));
    for (int i = 0; i < NSET; i++) begin
      hit[i] = vld_q[i] && slot_q[i] == tok_slot_i && tag_q[i] == tok_tag_i;
      rdy[i] = vld_q[i] && ((have_q[i] & need_i[slot_q[i]]) == need_i[slot_q[i]]);
    end
    for (int i = 0; i < NSET; i++) begin
      win[i] = rdy[i];
      for (int j = 0; j < NSET; j++)
        if (rdy[j] && older_q[j][i]) win[i] = 1'b0;
    end
    for (int i = NSET - 1; i >= 0; i--) begin
      if (hit[i])    hit_idx   = IW'(i);
      if (!vld_q[i]) alloc_idx = IW'(i);
      if (win[i])    fire_idx  = IW'(i);
    end
    any_hit     = |hit;
    any_free    = ~&vld_q;
    tok_ready_o = any_hit | any_free;
    acc         = tok_valid_i & tok_ready_o;
    wr_idx      = any_hit ? hit_idx : alloc_idx;
    fire_take_o = (|rdy) & fire_en_i;
  end

  assign fire_oh_o   = win;
  assign fire_slot_o = slot_q[fire_idx];
  assign fire_tag_o  = tag_q[fire_idx];
  assign fire_opnd_o = opnd_q[fire_idx];
  assign busy_o      = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      have_q  <= '0;
      older_q <= '0;
    end else begin
      if (fire_take_o) vld_q[fire_idx] <= 1'b0;
      if (acc) begin
        if (any_hit) begin
          have_q[hit_idx] <= have_q[hit_idx] | pbit;
        end else begin
          vld_q[alloc_idx]  <= 1'b1;
          have_q[alloc_idx] <= pbit;
          for (int j = 0; j < NSET; j++) older_q[j][alloc_idx] <= vld_q[j];
          older_q[alloc_idx] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc) begin
      if (!any_hit) begin
        slot_q[alloc_idx] <= tok_slot_i;
        tag_q[alloc_idx]  <= tok_tag_i;
      end
      for (int p = 0; p < NPORT; p++)
        if (pbit[p]) opnd_q[wr_idx][p] <= tok_data_i;
    end
  end
endmodule

// File: rtl/df_emit.sv
module df_emit #(
  parameter  int NDST = 4,
  parameter  int SW   = 3,
  parameter  int PW   = 2,
  parameter  int TW   = 8,
  parameter  int DW   = 16,
  localparam int DSTW = 1 + SW + PW,
  localparam int CW   = $clog2(NDST)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [DW-1:0]             data_i,
  input  logic [TW-1:0]             tag_i,
  input  logic [NDST-1:0][DSTW-1:0] dst_i,
  input  logic [NDST-1:0]           mask_i,
  output logic                      idle_o,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [SW-1:0]             out_slot_o,
  output logic [PW-1:0]             out_port_o,
  output logic [TW-1:0]             out_tag_o,
  output logic [DW-1:0]             out_data_o
);
  logic [NDST-1:0]           mask_q;
  logic [NDST-1:0][DSTW-1:0] dst_q;
  logic [DW-1:0]             data_q;
  logic [TW-1:0]             tag_q;
  logic [CW-1:0]             cur;

  always_comb begin
    cur = '0;
    for (int k = NDST - 1; k >= 0; k--) if (mask_q[k]) cur = CW'(k);
  end

  assign out_valid_o = |mask_q;
  assign idle_o      = ~out_valid_o;
  assign out_slot_o  = dst_q[cur][PW +: SW];
  assign out_port_o  = dst_q[cur][PW-1:0];
  assign out_tag_o   = tag_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q      <= '0;
    else if (load_i)                      mask_q      <= mask_i;
    else if (out_valid_o && out_ready_i)  mask_q[cur] <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      dst_q  <= dst_i;
      data_q <= data_i;
      tag_q  <= tag_i;
    end
  end
endmodule

// File: rtl/df_tile.sv
module df_tile import df_pkg::*; #(
  parameter  int NSLOT = 8,
  parameter  int NSET  = 8,
  parameter  int DW    = 16,
  parameter  int TW    = 8,
  parameter  int NDST  = 4,
  localparam int SW    = $clog2(NSLOT),
  localparam int PW    = $clog2(NPORT),
  localparam int DSTW  = 1 + SW + PW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_valid_i,
  input  logic [SW-1:0]        ld_slot_i,
  input  logic [2:0]           ld_op_i,
  input  logic [NDST*DSTW-1:0] ld_dst_i,
  input  logic                 tok_valid_i,
  output logic                 tok_ready_o,
  input  logic [SW-1:0]        tok_slot_i,
  input  logic [PW-1:0]        tok_port_i,
  input  logic [TW-1:0]        tok_tag_i,
  input  logic [DW-1:0]        tok_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [SW-1:0]        out_slot_o,
  output logic [PW-1:0]        out_port_o,
  output logic [TW-1:0]        out_tag_o,
  output logic [DW-1:0]        out_data_o
);
  df_op_e                            op_q [NSLOT];
  logic [NSLOT-1:0][NDST-1:0][DSTW-1:0] dst_q;
  logic [NSLOT-1:0][NPORT-1:0]       need;

  logic                      fire_take, em_idle;
  logic [NSET-1:0]           fire_oh, busy;
  logic [SW-1:0]             fire_slot;
  logic [TW-1:0]             fire_tag, res_tag;
  logic [NPORT-1:0][DW-1:0]  fire_opnd;
  logic [DW-1:0]             res_data;
  logic [NDST-1:0]           send_mask;
  df_op_e                    fire_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) op_q[s] <= OP_PASS;
      dst_q <= '0;
    end else if (ld_valid_i) begin
      op_q[ld_slot_i]  <= df_op_e'(ld_op_i);
      dst_q[ld_slot_i] <= ld_dst_i;
    end
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) need[s] = op_need(op_q[s]);
  end

  assign fire_op = op_q[fire_slot];

  df_match #(.NSET(NSET), .NSLOT(NSLOT), .TW(TW), .DW(DW)) i_match (
    .clk_i, .rst_ni, .tok_valid_i, .tok_ready_o, .tok_slot_i, .tok_port_i,
    .tok_tag_i, .tok_data_i,
    .need_i      (need),
    .fire_en_i   (em_idle),
    .fire_take_o (fire_take),
    .fire_oh_o   (fire_oh),
    .fire_slot_o (fire_slot),
    .fire_tag_o  (fire_tag),
    .fire_opnd_o (fire_opnd),
    .busy_o      (busy)
  );

  df_alu #(.DW(DW), .TW(TW), .NDST(NDST), .DSTW(DSTW)) i_alu (
    .op_i   (fire_op),
    .opnd_i (fire_opnd),
    .tag_i  (fire_tag),
    .dst_i  (dst_q[fire_slot]),
    .data_o (res_data),
    .tag_o  (res_tag),
    .mask_o (send_mask)
  );

  df_emit #(.NDST(NDST), .SW(SW), .PW(PW), .TW(TW), .DW(DW)) i_emit (
    .clk_i, .rst_ni,
    .load_i  (fire_take),
    .data_i  (res_data),
    .tag_i   (res_tag),
    .dst_i   (dst_q[fire_slot]),
    .mask_i  (send_mask),
    .idle_o  (em_idle),
    .out_valid_o, .out_ready_i, .out_slot_o, .out_port_o, .out_tag_o, .out_data_o
  );
endmodule

// File: rtl/df_tile_chk.sv
module df_tile_chk #(
  parameter int DW   = 16,
  parameter int TW   = 8,
  parameter int SW   = 3,
  parameter int PW   = 2,
  parameter int NSET = 8,
  parameter int NDST = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tok_valid_i,
  input logic            tok_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [SW-1:0]   out_slot_o,
  input logic [PW-1:0]   out_port_o,
  input logic [TW-1:0]   out_tag_o,
  input logic [DW-1:0]   out_data_o,
  input logic            fire_take,
  input logic [2:0]      fire_op,
  input logic [TW-1:0]   fire_tag,
  input logic [NSET-1:0] fire_oh,
  input logic [NSET-1:0] busy,
  input logic [NDST-1:0] send_mask
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_tag_o)
      && $stable(out_slot_o) && $stable(out_port_o)); // R10
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && !tok_ready_o |-> &busy); // R11
  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire_oh)); // R12
  AST_FIRE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_take |-> !out_valid_o); // R9
  AST_EMIT_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_take && (|send_mask) |=> out_valid_o); // R9
  AST_WADV_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_take && fire_op == df_pkg::OP_WADV |=> out_tag_o == TW'($past(fire_tag) + 1'b1)); // R8
  AST_TAG_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_take && fire_op != df_pkg::OP_WADV |=> out_tag_o == $past(fire_tag)); // R8
endmodule

bind df_tile df_tile_chk #(.DW(DW), .TW(TW), .SW(SW), .PW(PW), .NSET(NSET), .NDST(NDST)) i_df_tile_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tok_valid_i(tok_valid_i), .tok_ready_o(tok_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_slot_o(out_slot_o),
  .out_port_o(out_port_o), .out_tag_o(out_tag_o), .out_data_o(out_data_o),
  .fire_take(fire_take), .fire_op(fire_op), .fire_tag(fire_tag), .fire_oh(fire_oh),
  .busy(busy), .send_mask(send_mask)
);

// File: tb/test_df_tile.sv
module test_df_tile;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_slot = '0, ld_op = '0;
  logic [23:0] ld_dst = '0;
  logic        tok_valid = 1'b0, tok_ready;
  logic [2:0]  tok_slot = '0;
  logic [1:0]  tok_port = '0;
  logic [7:0]  tok_tag = '0;
  logic [15:0] tok_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [2:0]  out_slot;
  logic [1:0]  out_port;
  logic [7:0]  out_tag;
  logic [15:0] out_data;

  df_tile i_df_tile (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_slot_i(ld_slot), .ld_op_i(ld_op),
    .ld_dst_i(ld_dst), .tok_valid_i(tok_valid), .tok_ready_o(tok_ready), .tok_slot_i(tok_slot),
    .tok_port_i(tok_port), .tok_tag_i(tok_tag), .tok_data_i(tok_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_slot_o(out_slot), .out_port_o(out_port), .out_tag_o(out_tag),
    .out_data_o(out_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, r_cnt = 0;
  int r_slot[4096], r_port[4096], r_tag[4096], r_data[4096];

  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready && r_cnt < 4096) begin
      r_slot[r_cnt] = out_slot; r_port[r_cnt] = out_port;
      r_tag[r_cnt]  = out_tag;  r_data[r_cnt] = out_data;
      r_cnt++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_tok(string req, int i, int s, int p, int t, int d);
    chk(req, "slot", r_slot[i], s);
    chk(req, "port", r_port[i], p);
    chk(req, "tag",  r_tag[i],  t);
    chk(req, "data", r_data[i], d);
  endtask

  function automatic logic [5:0] dst(int s, int p);
    return {1'b1, 3'(s), 2'(p)};
  endfunction

  task automatic load(int s, int op, logic [23:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_slot = 3'(s); ld_op = 3'(op); ld_dst = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic drive(int s, int p, int t, int d);
    tok_valid = 1'b1; tok_slot = 3'(s); tok_port = 2'(p); tok_tag = 8'(t); tok_data = 16'(d);
  endtask

  task automatic send(int s, int p, int t, int d);
    @(negedge clk);
    drive(s, p, t, d);
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int alu_exp(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return int'(16'(a + b));
      1: return int'(16'(a - b));
      2: return int'(a & b);
      default: return int'(a ^ b);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    int base;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7fff, 16'h8000, 16'hffff, 16'h1234, 16'ha5a5};

    settle(3);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    #15 rst_n = 1'b1;
    settle(2);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "tok_ready", int'(tok_ready), 1);
    chk("R1", "no output", r_cnt, 0);

    // R2 R5: arithmetic sweep, both operand orders
    for (int op = 0; op < 4; op++) begin
      load(op, op, {18'd0, dst(op + 4, 1)});
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          base = r_cnt;
          if ((ia + ib) % 2 == 1) begin
            send(op, 1, ia * 8 + ib, vals[ib]); send(op, 0, ia * 8 + ib, vals[ia]);
          end else begin
            send(op, 0, ia * 8 + ib, vals[ia]); send(op, 1, ia * 8 + ib, vals[ib]);
          end
          settle(8);
          chk("R5", "count", r_cnt - base, 1);
          chk_tok("R5", base, op + 4, 1, ia * 8 + ib, alu_exp(op, vals[ia], vals[ib]));
        end
      end
    end

    // R4 R6: select needs three operands
    load(4, 4, {18'd0, dst(2, 2)});
    for (int i = 0; i < 3; i++) begin
      int pr;
      pr = (i == 0) ? 0 : (i == 1) ? 1 : 16'h8000;
      base = r_cnt;
      send(4, 2, 70 + i, 16'h2222);
      send(4, 0, 70 + i, pr);
      settle(6);
      chk("R4", "no fire with 2 of 3", r_cnt - base, 0);
      send(4, 1, 70 + i, 16'h1111 + i);
      settle(6);
      chk("R6", "count", r_cnt - base, 1);
      chk_tok("R6", base, 2, 2, 70 + i, (pr != 0) ? 16'h1111 + i : 16'h2222);
    end

    // R7: steer by predicate
    load(5, 5, {dst(3, 1), dst(2, 1), dst(1, 1), dst(0, 1)});
    for (int i = 0; i < 2; i++) begin
      base = r_cnt;
      send(5, 0, 80 + i, i == 0 ? 5 : 0);
      settle(4);
      chk("R4", "steer no fire on p0 only", r_cnt - base, 0);
      send(5, 1, 80 + i, 16'hbeef);
      settle(8);
      chk("R7", "count", r_cnt - base, 2);
      chk_tok("R7", base,     i == 0 ? 0 : 2, 1, 80 + i, 16'hbeef);
      chk_tok("R7", base + 1, i == 0 ? 1 : 3, 1, 80 + i, 16'hbeef);
    end

    // R8: tag advance with wrap; only dests 0 and 1 valid
    load(6, 6, {12'd0, dst(6, 0), dst(5, 2)});
    for (int i = 0; i < 3; i++) begin
      int t;
      t = (i == 0) ? 0 : (i == 1) ? 5 : 255;
      base = r_cnt;
      send(6, 0, t, 16'h0c00 + i);
      settle(8);
      chk("R8", "count", r_cnt - base, 2);
      chk_tok("R8", base,     5, 2, (t + 1) % 256, 16'h0c00 + i);
      chk_tok("R8", base + 1, 6, 0, (t + 1) % 256, 16'h0c00 + i);
    end

    // R9: four destinations in ascending order, tag copied
    load(7, 7, {dst(3, 0), dst(2, 2), dst(1, 1), dst(0, 0)});
    base = r_cnt;
    send(7, 0, 33, 16'h4321);
    settle(10);
    chk("R9", "count", r_cnt - base, 4);
    for (int k = 0; k < 4; k++) chk_tok("R9", base + k, k, (k == 3) ? 0 : k, 33, 16'h4321);

    // R3: two instances of one slot, interleaved
    base = r_cnt;
    send(0, 0, 40, 1); send(0, 0, 41, 100); send(0, 1, 41, 7); send(0, 1, 40, 3);
    settle(8);
    chk("R3", "count", r_cnt - base, 2);
    chk_tok("R3", base,     4, 1, 41, 107);
    chk_tok("R3", base + 1, 4, 1, 40, 4);

    // R12: older entry sits at higher index
    base = r_cnt;
    send(1, 0, 90, 50);
    send(0, 0, 50, 1);
    send(1, 1, 90, 8);
    settle(6);
    out_ready = 1'b0;
    send(7, 0, 91, 9);
    send(0, 0, 51, 2);
    send(0, 1, 51, 20);
    send(0, 1, 50, 10);
    settle(4);
    chk("R10", "held valid", int'(out_valid), 1);
    @(negedge clk); out_ready = 1'b1;
    settle(12);
    chk("R12", "count", r_cnt - base, 7);
    chk_tok("R12", base, 5, 1, 90, 42);
    chk_tok("R12", base + 5, 4, 1, 50, 11);
    chk_tok("R12", base + 6, 4, 1, 51, 22);

    // R11: full store stalls unmatched token, accepts matching one
    base = r_cnt;
    @(negedge clk); out_ready = 1'b0;
    send(7, 0, 99, 7);
    for (int t = 100; t < 108; t++) send(0, 0, t, t);
    @(negedge clk); drive(0, 0, 108, 108); #1;
    chk("R11", "ready low when full", int'(tok_ready), 0);
    settle(3);
    chk("R11", "ready still low", int'(tok_ready), 0);
    tok_valid = 1'b0;
    @(negedge clk); drive(0, 1, 100, 1000); #1;
    chk("R11", "hit accepted when full", int'(tok_ready), 1);
    @(negedge clk); drive(0, 0, 108, 108); #1;
    chk("R11", "unmatched still stalled", int'(tok_ready), 0);
    out_ready = 1'b1;
    while (!tok_ready) @(negedge clk);
    @(negedge clk); tok_valid = 1'b0;
    for (int t = 101; t < 109; t++) send(0, 1, t, 1000);
    settle(20);
    chk("R11", "count", r_cnt - base, 13);
    for (int t = 100; t < 109; t++) chk_tok("R11", base + 4 + (t - 100), 4, 1, t, t + 1000);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule